// File: doc/BRIEF.md
# Boot-Loaded Lookup-Table Address Decoder

This block produces the chip-select and control strobes for a small 8-bit processor bus by looking each bus address up in an on-chip decode table, instead of deriving the strobes from fixed gate logic. The table contents are not wired in. After every reset the block copies them out of a boot ROM into its own table storage, and the processor is kept in reset for the whole copy.

A single timer steps through the table indices and presents each one to the ROM read port. The returned byte is written to the same table row. The timer keeps running for a short margin after the last row. When it reaches its terminal count, the ROM port is switched off, the table goes into run mode and the processor reset is released. From that point on, each processor address selects one table row, and the bits of that row drive the select outputs.

In the default coarse configuration, one table row covers an aligned 8-byte block of the address space. This cuts the table to one eighth of the full address range.

Top module: `lut_addr_decoder`

## Requirements
- R1: From reset until run mode begins, `cpu_rst_n` is low (the processor is held in reset); while `rst_n` is low, `done` and `cpu_rst_n` are low and `sel` is all zero.
- R2: After reset is released, `rom_addr` starts at 0 and advances by one on every clock edge. `rom_en` is high for exactly DEPTH consecutive cycles, one for each row index 0 to DEPTH-1. DEPTH is 8192 by default.
- R3: The byte on `rom_data` while `rom_addr` equals N is stored in table row N, and is the value later returned for every address mapping to row N.
- R4: Run mode starts at the clock edge numbered DEPTH+MARGIN after reset release, where MARGIN is 16 by default. From then on `rom_en` stays low.
- R5: In run mode, `sel` takes the table row of `cpu_addr` at each clock edge. The output is registered, so it changes only at the edge after `cpu_addr` changes. Bit i of the row drives `sel[i]` and is active high.
- R6: With COARSE=1, the row index is `cpu_addr[15:3]` and address bits 2:0 have no effect on `sel`.
- R7: While the table is loading, `sel` stays all zero whatever `cpu_addr` does.
- R8: `done` rises together with `cpu_rst_n` when run mode begins and stays high until the next reset. A reset applied partway through a load clears `done` and restarts the copy from row 0, with the full DEPTH+MARGIN wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a new table load |
| rom_en | output | 1 | Boot ROM read enable, high during the copy |
| rom_addr | output | TBL_AW (13) | Boot ROM row index being copied |
| rom_data | input | SEL_W (8) | Boot ROM data for `rom_addr`, valid in the same cycle |
| cpu_addr | input | ADDR_W (16) | Processor bus address |
| cpu_rst_n | output | 1 | Active-low processor reset |
| sel | output | SEL_W (8) | Decoded select outputs, active high |
| done | output | 1 | High once run mode is active |

## Verification
The bench targets the load timing edges. It counts the exact edge at which `done` rises and the exact number of `rom_en` cycles. An off-by-one timer would release the processor a cycle early or late, or would copy one row too few or too many. Those errors would show up as a wrong last row (address 0xFFFF) or a wrong first row (address 0x0000).

It drives changing addresses during the load. A decoder that let the table drive `sel` early would raise selects while the processor is still held in reset.

Pairs of addresses that differ only in bits 2:0 show whether the coarse index was taken from the wrong bits. A reset applied partway through a load, followed by a full re-timing, catches a `done` flag or a timer that does not clear.

// File: rtl/lut_addr_decoder.sv
module lut_addr_decoder #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 8,
  parameter bit COARSE = 1'b1,
  parameter int BLK_SH = 3,
  parameter int MARGIN = 16,
  localparam int DROP   = COARSE ? BLK_SH : 0,
  localparam int TBL_AW = ADDR_W - DROP
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rom_en,
  output logic [TBL_AW-1:0] rom_addr,
  input  logic [SEL_W-1:0]  rom_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_rst_n,
  output logic [SEL_W-1:0]  sel,
  output logic              done
);

  localparam int DEPTH = 1 << TBL_AW;
  localparam int LAST  = DEPTH + MARGIN - 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [SEL_W-1:0]  tbl [DEPTH];
  logic [CNT_W-1:0]  tmr;
  logic              run;
  logic              loading;
  logic [TBL_AW-1:0] row;

  assign loading   = tmr < CNT_W'(DEPTH);
  assign row       = cpu_addr[ADDR_W-1:DROP];
  assign rom_en    = loading;
  assign rom_addr  = tmr[TBL_AW-1:0];
  assign cpu_rst_n = run;
  assign done      = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      run <= 1'b0;
    end else if (!run) begin
      if (tmr == CNT_W'(LAST)) run <= 1'b1;
      else                     tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !run && loading) tbl[tmr[TBL_AW-1:0]] <= rom_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else        sel <= run ? tbl[row] : '0;
  end

endmodule

// File: rtl/lut_addr_decoder_chk.sv
module lut_addr_decoder_chk #(
  parameter int AW = 13,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rom_en,
  input logic [AW-1:0] rom_addr,
  input logic          cpu_rst_n,
  input logic [SW-1:0] sel,
  input logic          done
);

  AST_HOLD_WHILE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> !cpu_rst_n); // R1

  AST_ROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rom_en && $past(rom_en)) |-> rom_addr == AW'($past(rom_addr) + 1'b1)); // R2

  AST_ROM_OFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rom_en); // R4

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> sel == '0); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8

endmodule

bind lut_addr_decoder lut_addr_decoder_chk #(.AW(TBL_AW), .SW(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .rom_addr(rom_addr),
  .cpu_rst_n(cpu_rst_n), .sel(sel), .done(done)
);

// File: tb/lut_addr_decoder_tb.sv
module lut_addr_decoder_tb;
  localparam int TBL_AW = 13;
  localparam int DEPTH  = 8192;
  localparam int MARGIN = 16;
  localparam int NV     = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h0007, 16'h0008, 16'hFFFF, 16'hFFF8, 16'h1234,
    16'h8000, 16'h7FFF, 16'hABCD, 16'h00FF, 16'h0100, 16'hC3A5
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rom_en;
  logic [TBL_AW-1:0] rom_addr;
  logic [7:0]        rom_data;
  logic [15:0]       cpu_addr;
  logic              cpu_rst_n;
  logic [7:0]        sel;
  logic              done;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] romf(input logic [12:0] i);
    return (i[7:0] * 8'd29 + 8'd7) ^ {3'b000, i[12:8]};
  endfunction

  assign rom_data = romf(rom_addr);

  lut_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_data), .cpu_addr(cpu_addr), .cpu_rst_n(cpu_rst_n),
    .sel(sel), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_and_time();
    int n = 0;
    int en_cnt = 0;
    int bad_step = 0;
    int loud = 0;
    rst_n = 1'b1;
    forever begin
      if (done) break;
      if (rom_en) begin
        if (rom_addr != TBL_AW'(en_cnt)) bad_step++;
        en_cnt++;
      end
      if (sel != 8'h00 || cpu_rst_n) loud++;
      cpu_addr = cpu_addr + 16'h0123;
      cyc();
      n++;
    end
    chk(n == DEPTH + MARGIN, "R4 R8 run-mode edge", n, DEPTH + MARGIN);
    chk(en_cnt == DEPTH, "R2 rom_en cycles", en_cnt, DEPTH);
    chk(bad_step == 0, "R2 rom_addr sequence", bad_step, 0);
    chk(loud == 0, "R1 R7 quiet during load", loud, 0);
    chk(!rom_en, "R4 rom_en off in run", rom_en, 0);
    chk(cpu_rst_n, "R8 cpu reset released with done", cpu_rst_n, 1);
  endtask

  task automatic probe(input logic [15:0] a, input string req);
    cpu_addr = a;
    cyc();
    chk(sel == romf(a[15:3]), req, sel, romf(a[15:3]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] first;
    rst_n = 1'b0;
    cpu_addr = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!cpu_rst_n && !done, "R1 reset outputs", {cpu_rst_n, done}, 0);
    chk(sel == 8'h00, "R1 sel in reset", sel, 0);
    chk(rom_en && rom_addr == 0, "R2 rom port in reset", {rom_en, rom_addr}, 14'h2000);

    load_and_time();

    for (int i = 0; i < NV; i++) probe(VEC[i], "R3 R5 table lookup");

    cpu_addr = 16'h4560;
    cyc();
    first = sel;
    cpu_addr = 16'h4567;
    cyc();
    chk(sel == first && first == romf(13'h08AC), "R6 low bits ignored", sel, romf(13'h08AC));
    cpu_addr = 16'h0008;
    #1;
    chk(sel == romf(13'h08AC), "R5 registered output", sel, romf(13'h08AC));
    cyc();
    chk(sel == romf(13'h0001), "R5 next edge", sel, romf(13'h0001));

    repeat (50) cyc();
    chk(done && cpu_rst_n && !rom_en, "R8 done sticky", {done, cpu_rst_n, rom_en}, 3'b110);

    rst_n = 1'b0;
    #1;
    chk(!done && !cpu_rst_n && sel == 0, "R8 reset clears run", {done, cpu_rst_n, sel}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (200) cyc();
    chk(!done && rom_addr == 200, "R2 partial load", rom_addr, 200);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rom_addr == 0 && !done, "R8 reset restarts copy", rom_addr, 0);

    load_and_time();
    probe(16'hFFFF, "R3 last row after reload");
    probe(16'h0003, "R6 first row after reload");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule